// File: doc/BRIEF.md
# Shift-and-Store Bus Register

This block is an eight-stage serial-to-parallel converter with a storage rank behind the shift rank. Each rising clock edge moves one bit from the serial input into stage 1 and pushes every other stage one place along. A strobe copies the shift contents into an eight-bit holding register. That register drives a parallel bus, and the bus can be released to high impedance so that several of these blocks can share one set of lines. Because the holding register only follows the shift rank while strobe is high, a controller can shift a new word in while the bus keeps showing the last one, and then update all eight lines together.

Two serial outputs let several blocks be chained into a longer register. The first output is stage 8 itself, so it changes on the rising edge. The second output is a copy of stage 8 that is captured on the falling edge half a clock later. The next block in the chain can then sample it safely when clock edges are slow or skewed. An asynchronous active-low reset clears every stage, the holding register and the late serial copy.

Top module: `shift_store_bus_reg`

## Requirements
- R1: On each rising clock edge, `ser_in` is loaded into stage 1 and each stage N (N = 2..8) takes the value that stage N-1 held before the edge.
- R2: If `strobe` is high at a rising edge, the holding register takes the shift contents produced by that edge. Holding bit i corresponds to stage i+1, so `par_q[0]` is stage 1 and `par_q[7]` is stage 8.
- R3: If `strobe` is low at a rising edge, the holding register keeps its value while shifting continues.
- R4: While `out_en` is high, `par_q` drives the holding register and `bus_drive` is 1.
- R5: While `out_en` is low, all bits of `par_q` are high impedance and `bus_drive` is 0. Shifting and strobing still take effect, and the result appears once `out_en` returns high.
- R6: `ser_q_rise` equals stage 8 and changes only at the rising edge.
- R7: `ser_q_fall` takes the value of stage 8 at each falling edge and holds it through the following rising edge.
- R8: While `rst_n` is low, all stages, the holding register and `ser_q_fall` are 0.
- R9: When two blocks are chained, with the second block's `ser_in` fed from either serial output of the first, sixteen shifts fill both blocks as one sixteen-stage register. The first block holds the most recent eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; rising edge shifts, falling edge updates the late serial copy |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data into stage 1 |
| strobe | input | 1 | Loads the holding register from the shift rank |
| out_en | input | 1 | High drives the parallel bus; low releases it to high impedance |
| par_q | output | 8 | Parallel bus from the holding register, bit 0 = stage 1 |
| bus_drive | output | 1 | High when the parallel bus is driven |
| ser_q_rise | output | 1 | Stage 8, updated at the rising edge |
| ser_q_fall | output | 1 | Stage 8, updated at the falling edge |

## Verification
Two blocks are chained, first through the rising-edge serial output and then through the falling-edge one. The same sixteen-bit model must hold for both paths, so a timing slip in the late copy would show up as a one-bit offset in the second block. Each pattern is shifted with strobe low, so the bus must stay frozen. Strobe is then raised for one edge and kept high for several more, so the bus must follow the shifting bit by bit. Bit patterns that alternate, run in groups and are asymmetric separate a reversed bit order from a correct one. A stretch with the bus released shows that shifting and strobing go on underneath the high-impedance outputs.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
package ssr_pkg;
  localparam int unsigned SSR_STAGES = 8;
endpackage

// File: rtl/ssr_shift_chain.sv
`timescale 1ns/1ps
module ssr_shift_chain #(
  parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  output logic [STAGES-1:0] stage_q,
  output logic [STAGES-1:0] stage_d
);
  // next-state: stage 0 takes the serial input, the rest take their neighbour
  always_comb stage_d[0] = ser_in;
  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_comb stage_d[g] = stage_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  // R1: every edge moves the chain by one place
  a_r1_shift: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stage_q[0] == $past(ser_in)) &&
             (stage_q[STAGES-1:1] == $past(stage_q[STAGES-2:0])));
endmodule

// File: rtl/ssr_store.sv
`timescale 1ns/1ps
module ssr_store #(
  parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [STAGES-1:0] din,
  output logic [STAGES-1:0] hold_q
);
  logic [STAGES-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (load) hold_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  // R3: without a load the stored word is frozen
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hold_q));
endmodule

// File: rtl/ssr_fall_tap.sv
`timescale 1ns/1ps
module ssr_fall_tap (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  output logic tap_q
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= 1'b0;
    else        tap_q <= src;
  end

  // R7: the late copy is the source as seen at the previous falling edge
  a_r7_fall: assert property (@(negedge clk) disable iff (!rst_n)
    1'b1 |=> tap_q == $past(src));
endmodule

// File: rtl/shift_store_bus_reg.sv
`timescale 1ns/1ps
module shift_store_bus_reg #(
  parameter int unsigned STAGES = ssr_pkg::SSR_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              strobe,
  input  logic              out_en,
  output logic [STAGES-1:0] par_q,
  output logic              bus_drive,
  output logic              ser_q_rise,
  output logic              ser_q_fall
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;
  logic [STAGES-1:0] hold_q;

  ssr_shift_chain #(.STAGES(STAGES)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_in  (ser_in),
    .stage_q (shift_q),
    .stage_d (shift_d)
  );

  ssr_store #(.STAGES(STAGES)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (strobe),
    .din    (shift_d),
    .hold_q (hold_q)
  );

  ssr_fall_tap u_tap (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (shift_q[LAST]),
    .tap_q (ser_q_fall)
  );

  assign ser_q_rise = shift_q[LAST];
  assign bus_drive  = out_en;
  assign par_q      = out_en ? hold_q : {STAGES{1'bz}};

  // R2: a strobed edge leaves storage equal to the freshly shifted stages
  a_r2_track: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> hold_q == shift_q);

  // R6: the early serial output is the stage 7 value from one edge back
  a_r6_rise: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ser_q_rise == $past(shift_q[LAST-1]));
endmodule

// File: tb/shift_store_bus_reg_bench.sv
`timescale 1ns/1ps
module shift_store_bus_reg_bench;
  logic clk = 1'b0;
  logic rst_n, din, stb, oe, use_fall, done;
  wire  [7:0] h_par, t_par;
  wire  h_drv, t_drv, h_rise, t_rise, h_fall, t_fall;
  wire  tail_in = use_fall ? h_fall : h_rise;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  shift_store_bus_reg u_shift_store_bus_reg (
    .clk(clk), .rst_n(rst_n), .ser_in(din), .strobe(stb), .out_en(oe),
    .par_q(h_par), .bus_drive(h_drv), .ser_q_rise(h_rise), .ser_q_fall(h_fall));

  shift_store_bus_reg u_tail (
    .clk(clk), .rst_n(rst_n), .ser_in(tail_in), .strobe(stb), .out_en(oe),
    .par_q(t_par), .bus_drive(t_drv), .ser_q_rise(t_rise), .ser_q_fall(t_fall));

  // reference: one sixteen-bit queue, index 0 = newest bit
  bit         chain[$];
  logic [7:0] m_hh, m_th;
  logic       m_hf, m_tf;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic tick(logic d, logic s, logic e);
    logic [7:0] exp_h, exp_t;
    din = d; stb = s; oe = e;
    @(posedge clk);
    chain.push_front(d);
    void'(chain.pop_back());
    if (s) for (int i = 0; i < 8; i++) begin
      m_hh[i] = chain[i];
      m_th[i] = chain[8+i];
    end
    #1;
    exp_h = e ? m_hh : 8'bzzzzzzzz;
    exp_t = e ? m_th : 8'bzzzzzzzz;
    if (!e)     chk("R5 head bus", h_par, exp_h);
    else if (s) chk("R2 head bus", h_par, exp_h);
    else        chk("R3 head bus", h_par, exp_h);
    chk("R9 tail bus", t_par, exp_t);
    chk("R4 drive", {7'd0, h_drv}, {7'd0, e});
    chk("R6 head early serial", {7'd0, h_rise}, {7'd0, chain[7]});
    chk("R1 tail early serial", {7'd0, t_rise}, {7'd0, chain[15]});
    chk("R7 late serial held over rising edge", {7'd0, h_fall}, {7'd0, m_hf});
    @(negedge clk);
    m_hf = chain[7];
    m_tf = chain[15];
    #1;
    chk("R7 head late serial", {7'd0, h_fall}, {7'd0, m_hf});
    chk("R7 tail late serial", {7'd0, t_fall}, {7'd0, m_tf});
  endtask

  task automatic run_pattern(logic [15:0] pat);
    for (int i = 0; i < 16; i++) tick(pat[i], 1'b0, 1'b1);  // R3: frozen bus
    tick(1'b1, 1'b1, 1'b1);                                 // single strobe
    for (int i = 0; i < 5; i++) tick(pat[i], 1'b1, 1'b1);   // R2: tracking
    for (int i = 0; i < 4; i++) tick(~pat[i], 1'b0, 1'b1);  // R3: hold
    for (int i = 0; i < 3; i++) tick(pat[i+4], 1'b1, 1'b0); // R5: released
    tick(1'b0, 1'b0, 1'b1);                                 // R5: result visible
  endtask

  initial begin
    done = 1'b0;
    rst_n = 1'b0; din = 1'b0; stb = 1'b0; oe = 1'b1; use_fall = 1'b0;
    for (int i = 0; i < 16; i++) chain.push_back(1'b0);
    m_hh = '0; m_th = '0; m_hf = 1'b0; m_tf = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R8 reset head bus", h_par, 8'h00);
    chk("R8 reset tail bus", t_par, 8'h00);
    chk("R8 reset early serial", {7'd0, h_rise}, 8'h00);
    chk("R8 reset late serial", {7'd0, h_fall}, 8'h00);
    rst_n = 1'b1;

    use_fall = 1'b0;
    run_pattern(16'hA5C3);
    run_pattern(16'h0F01);
    use_fall = 1'b1;
    run_pattern(16'h3C96);
    run_pattern(16'hF0AA);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule